// File: doc/BRIEF.md
# Double-Buffered Alternating-Reload PWM Timer

This block is a down-counting timer that draws a pulse-width modulated waveform by reloading itself from two values in turn. The "high" value sets how many count ticks the output stays at 1. The "low" value sets how many ticks it stays at 0. Counting advances only on cycles where the tick input is set, so any slower count rate can be derived outside the block.

The two reload values sit in two banks. Only one bank is active at a time. Software can stage a new high/low pair in the idle bank while the waveform keeps running. It then requests an exchange. The exchange waits until the end of the current low phase, so the next full period uses both new values together. A period built from a new high time and an old low time, or the other way round, cannot occur.

Software controls the counter with three strobes. Clear stops and zeroes the counter. Load restarts a high phase from the active high value. Arm lets counting run.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: Once armed with tick held at 1, the output alternates between 1 for H cycles and 0 for L cycles. H is the active bank's high value and L is its low value.
- R2: After reset, and after a load while not armed, the output is 0 and swap_pending is 0.
- R3: With wr_inactive at 0, a write goes to the active bank. A new low value written during a high phase sets the length of the low phase that follows.
- R4: An accepted exchange request while running takes effect only when a low phase ends. The next period uses the new high value and the new low value together.
- R5: A swap_start pulse while swap_enable is 0 has no effect: swap_pending stays 0 and the waveform keeps its values.
- R6: swap_pending is 1 from the cycle after an accepted request until the exchange is applied.
- R7: A second swap_start while an exchange is already pending is ignored, so the banks are exchanged exactly once.
- R8: A stored value of 0 counts as 1 tick, so neither phase can vanish.
- R9: The counter changes only on cycles with tick at 1. Holding tick at 0 for N cycles lengthens the current phase by N cycles.
- R10: cnt_reset disarms the counter, which drives the output to 0. cnt_load restarts a full high phase from the active high value.
- R11: When the counter is not armed, a pending exchange is applied on the next clock. The counter is reloaded with the new high value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; the counter advances on clocks where this is 1 |
| wr_a | input | 1 | Write strobe for the high-time value |
| wr_b | input | 1 | Write strobe for the low-time value |
| wr_data | input | CNT_W | Value to write |
| wr_inactive | input | 1 | 0: writes go to the active bank; 1: writes go to the idle bank |
| swap_enable | input | 1 | Must be 1 for swap_start to be accepted |
| swap_start | input | 1 | Bank exchange request strobe |
| cnt_reset | input | 1 | Clear strobe: disarms and zeroes the counter |
| cnt_load | input | 1 | Load strobe: counter takes the active high value and starts a high phase |
| arm | input | 1 | Arm strobe: starts counting |
| pwm_out | output | 1 | PWM output; 0 while not armed |
| swap_pending | output | 1 | An exchange has been accepted but not yet applied |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle: phase flips at each terminal count, bank selection stays still except at a low-phase end, the pending flag is held, requests made without the enable are refused, the counter is frozen without tick, and no reload is zero. Only the bench scenarios can show the waveform run lengths themselves. These are the exact high and low lengths, the absence of a mixed period around an exchange, the single exchange after a doubled request, and the stretching of a phase by held ticks.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_a,
  input  logic         wr_b,
  input  logic [W-1:0] wr_data,
  input  logic         wr_inactive,
  input  logic         swap_enable,
  input  logic         swap_start,
  input  logic         swap_window,
  output logic [W-1:0] reload_a,
  output logic [W-1:0] reload_b,
  output logic         swap_take,
  output logic         swap_pending,
  output logic         active_sel
);
  localparam int NB = 2;

  logic [W-1:0] a_q [NB];
  logic [W-1:0] b_q [NB];
  logic         tgt;
  logic         pend_q, pend_d;
  logic         sel_q, sel_d;
  logic [W-1:0] raw_a;

  // Write routing: the active bank or the idle one
  assign tgt = wr_inactive ? ~sel_q : sel_q;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic         hit;
    logic [W-1:0] a_r, b_r;
    assign hit = (tgt == 1'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        b_r <= '0;
      end else begin
        if (wr_a && hit) a_r <= wr_data;
        if (wr_b && hit) b_r <= wr_data;
      end
    end

    assign a_q[g] = a_r;
    assign b_q[g] = b_r;
  end

  assign swap_take = pend_q && swap_window;

  always_comb begin
    pend_d = pend_q;
    sel_d  = sel_q;
    if (swap_take) begin
      pend_d = 1'b0;
      sel_d  = ~sel_q;
    end else if (!pend_q && swap_start && swap_enable) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      sel_q  <= sel_d;
    end
  end

  // During an exchange, the high reload already comes from the new bank
  assign raw_a    = swap_take ? a_q[~sel_q] : a_q[sel_q];
  assign reload_a = (raw_a == '0) ? W'(1) : raw_a;
  assign reload_b = (b_q[sel_q] == '0) ? W'(1) : b_q[sel_q];

  assign swap_pending = pend_q;
  assign active_sel   = sel_q;
endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter
  import pwm_dbuf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_reset,
  input  logic         cnt_load,
  input  logic         arm,
  input  logic [W-1:0] reload_a,
  input  logic [W-1:0] reload_b,
  input  logic         swap_take,
  output logic         swap_window,
  output logic         armed,
  output logic         phase_low,
  output logic         at_tc,
  output logic [W-1:0] count,
  output logic         pwm_out
);
  logic [W-1:0] cnt_q, cnt_d;
  phase_e       ph_q, ph_d;
  logic         arm_q, arm_d;
  logic         adv;

  assign at_tc       = (cnt_q[W-1:1] == '0);
  assign adv         = arm_q && tick && !cnt_reset && !cnt_load;
  assign swap_window = !arm_q || (adv && at_tc && (ph_q == PH_LOW));

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    arm_d = arm_q;
    if (cnt_reset) begin
      cnt_d = '0;
      ph_d  = PH_HIGH;
      arm_d = 1'b0;
    end else begin
      if (arm) arm_d = 1'b1;
      if (cnt_load || (!arm_q && swap_take)) begin
        cnt_d = reload_a;
        ph_d  = PH_HIGH;
      end else if (adv) begin
        if (at_tc) begin
          if (ph_q == PH_HIGH) begin
            ph_d  = PH_LOW;
            cnt_d = reload_b;
          end else begin
            ph_d  = PH_HIGH;
            cnt_d = reload_a;
          end
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_HIGH;
      arm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      arm_q <= arm_d;
    end
  end

  assign armed     = arm_q;
  assign phase_low = (ph_q == PH_LOW);
  assign count     = cnt_q;
  assign pwm_out   = arm_q && (ph_q == PH_HIGH);
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wr_inactive,
  input  logic             swap_enable,
  input  logic             swap_start,
  input  logic             cnt_reset,
  input  logic             cnt_load,
  input  logic             arm,
  output logic             pwm_out,
  output logic             swap_pending
);
  logic             rst_ns;
  logic [CNT_W-1:0] reload_a, reload_b, count;
  logic             swap_take, swap_window, armed, phase_low, at_tc, active_sel;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  pwm_bank_regs #(.W(CNT_W)) u_banks (
    .clk          (clk),
    .rst_n        (rst_ns),
    .wr_a         (wr_a),
    .wr_b         (wr_b),
    .wr_data      (wr_data),
    .wr_inactive  (wr_inactive),
    .swap_enable  (swap_enable),
    .swap_start   (swap_start),
    .swap_window  (swap_window),
    .reload_a     (reload_a),
    .reload_b     (reload_b),
    .swap_take    (swap_take),
    .swap_pending (swap_pending),
    .active_sel   (active_sel)
  );

  pwm_down_counter #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_ns),
    .tick        (tick),
    .cnt_reset   (cnt_reset),
    .cnt_load    (cnt_load),
    .arm         (arm),
    .reload_a    (reload_a),
    .reload_b    (reload_b),
    .swap_take   (swap_take),
    .swap_window (swap_window),
    .armed       (armed),
    .phase_low   (phase_low),
    .at_tc       (at_tc),
    .count       (count),
    .pwm_out     (pwm_out)
  );
endmodule

// File: rtl/pwm_dbuf_checker.sv
module pwm_dbuf_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_ns,
  input logic         tick,
  input logic         swap_start,
  input logic         swap_enable,
  input logic         cnt_reset,
  input logic         cnt_load,
  input logic         armed,
  input logic         phase_low,
  input logic         at_tc,
  input logic         active_sel,
  input logic [W-1:0] count,
  input logic         pwm_out,
  input logic         swap_pending
);
  logic run_step;
  assign run_step = armed && tick && !cnt_reset && !cnt_load;

  // R1: each terminal count while running flips the phase
  assert_phase_flip_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_step && at_tc) |=> (phase_low != $past(phase_low)));

  // R10: clearing drives the output idle
  assert_clear_idle_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    cnt_reset |=> !pwm_out);

  // R4: while running, the bank only changes at the end of a low phase
  assert_swap_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (armed && !(run_step && at_tc && phase_low)) |=> $stable(active_sel));

  // R5: no request is accepted without the enable
  assert_no_start_without_enable_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (!swap_pending && !(swap_start && swap_enable)) |=> !swap_pending);

  // R6: a pending request is held until the low phase ends
  assert_pending_held_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (swap_pending && armed && !(run_step && at_tc && phase_low)) |=> swap_pending);

  // R8: a reload never leaves a zero count
  assert_reload_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_step && at_tc) |=> (count != '0));

  // R9: without a tick the count holds
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (armed && !tick && !cnt_reset && !cnt_load) |=> $stable(count));
endmodule

bind pwm_dbuf_timer pwm_dbuf_checker #(.W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_ns       (rst_ns),
  .tick         (tick),
  .swap_start   (swap_start),
  .swap_enable  (swap_enable),
  .cnt_reset    (cnt_reset),
  .cnt_load     (cnt_load),
  .armed        (armed),
  .phase_low    (phase_low),
  .at_tc        (at_tc),
  .active_sel   (active_sel),
  .count        (count),
  .pwm_out      (pwm_out),
  .swap_pending (swap_pending)
);

// File: tb/pwm_dbuf_timer_tb.sv
module pwm_dbuf_timer_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n, tick, wr_a, wr_b, wr_inactive, swap_enable, swap_start;
  logic cnt_reset, cnt_load, arm;
  logic [W-1:0] wr_data;
  logic pwm_out, swap_pending;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit mon_lvl = 1'b0;
  int mon_len = 0;

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } run_t;
  run_t expq[$];

  always #4 clk = ~clk;

  pwm_dbuf_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_a(wr_a), .wr_b(wr_b),
    .wr_data(wr_data), .wr_inactive(wr_inactive), .swap_enable(swap_enable),
    .swap_start(swap_start), .cnt_reset(cnt_reset), .cnt_load(cnt_load),
    .arm(arm), .pwm_out(pwm_out), .swap_pending(swap_pending)
  );

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 50000", cyc);
      report();
      $finish;
    end
  end

  // Monitor: measures complete runs of the output and compares them
  always @(negedge clk) begin
    if (!mon_en) begin
      mon_lvl = 1'b0;
      mon_len = 0;
    end else if (pwm_out != mon_lvl) begin
      if (mon_len > 0 && expq.size() > 0) begin
        run_t e;
        e = expq.pop_front();
        checks++;
        if (e.lvl != mon_lvl || e.len != mon_len) begin
          errors++;
          $display("FAIL %s: actual level %0d len %0d expected level %0d len %0d",
                   e.tag, mon_lvl, mon_len, e.lvl, e.len);
        end
      end
      mon_lvl = pwm_out;
      mon_len = 1;
    end else if (mon_len > 0) begin
      mon_len++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic actual, logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, actual, expected);
    end
  endtask

  task automatic push(bit lvl, int len, string tag);
    run_t r;
    r.lvl = lvl; r.len = len; r.tag = tag;
    expq.push_back(r);
  endtask

  task automatic write_a(int v);
    wr_data = W'(v); wr_a = 1'b1; step(1); wr_a = 1'b0;
  endtask

  task automatic write_b(int v);
    wr_data = W'(v); wr_b = 1'b1; step(1); wr_b = 1'b0;
  endtask

  task automatic setup(int a, int b);
    cnt_reset = 1'b1; step(1); cnt_reset = 1'b0;
    wr_inactive = 1'b0;
    write_a(a);
    write_b(b);
    cnt_load = 1'b1; step(1); cnt_load = 1'b0;
  endtask

  task automatic start_run();
    mon_en = 1'b1;
    arm = 1'b1; step(1); arm = 1'b0;
  endtask

  task automatic drain(string tag);
    int t = 0;
    while (expq.size() > 0 && t < 300) begin
      step(1);
      t++;
    end
    if (expq.size() > 0) begin
      checks++;
      errors++;
      $display("FAIL %s: actual %0d runs missing expected 0", tag, expq.size());
      expq.delete();
    end
    mon_en = 1'b0;
    cnt_reset = 1'b1; step(1); cnt_reset = 1'b0;
    check({tag, " R10 idle after clear"}, pwm_out, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; wr_a = 1'b0; wr_b = 1'b0; wr_data = '0;
    wr_inactive = 1'b0; swap_enable = 1'b0; swap_start = 1'b0;
    cnt_reset = 1'b0; cnt_load = 1'b0; arm = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(4);
    check("R2 reset output", pwm_out, 1'b0);
    check("R2 reset pending", swap_pending, 1'b0);

    // R1 basic alternation; R2 idle before arm
    setup(3, 5);
    step(3);
    check("R2 loaded but unarmed", pwm_out, 1'b0);
    push(1, 3, "R1"); push(0, 5, "R1"); push(1, 3, "R1"); push(0, 5, "R1");
    start_run();
    drain("R1");

    // R3 write to the active bank takes effect at next reload
    setup(3, 3);
    push(1, 3, "R3"); push(0, 5, "R3"); push(1, 3, "R3"); push(0, 5, "R3");
    start_run();
    write_b(5);
    drain("R3");

    // R10 load restarts a high phase
    setup(4, 4);
    push(1, 7, "R10"); push(0, 4, "R10"); push(1, 4, "R10");
    start_run();
    step(2);
    cnt_load = 1'b1; step(1); cnt_load = 1'b0;
    drain("R10");

    // R4/R6/R7 exchange at a period boundary, doubled request
    setup(4, 6);
    push(1, 4, "R4"); push(0, 6, "R4"); push(1, 8, "R4");
    push(0, 2, "R4"); push(1, 8, "R7"); push(0, 2, "R7");
    start_run();
    wr_inactive = 1'b1;
    write_a(8);
    write_b(2);
    swap_enable = 1'b1;
    swap_start = 1'b1; step(1); swap_start = 1'b0;
    check("R6 pending after accept", swap_pending, 1'b1);
    swap_start = 1'b1; step(1); swap_start = 1'b0;
    check("R6 pending held", swap_pending, 1'b1);
    while (expq.size() > 2) step(1);
    check("R7 single exchange, pending cleared", swap_pending, 1'b0);
    swap_enable = 1'b0;
    wr_inactive = 1'b0;
    drain("R4");

    // R5 request without enable is ignored
    setup(3, 3);
    wr_inactive = 1'b1;
    write_a(6);
    write_b(6);
    wr_inactive = 1'b0;
    push(1, 3, "R5"); push(0, 3, "R5"); push(1, 3, "R5"); push(0, 3, "R5");
    start_run();
    swap_start = 1'b1; step(1); swap_start = 1'b0;
    check("R5 pending stays low", swap_pending, 1'b0);
    drain("R5");

    // R11 exchange while unarmed applies at once
    setup(3, 3);
    wr_inactive = 1'b1;
    write_a(5);
    write_b(1);
    swap_enable = 1'b1;
    swap_start = 1'b1; step(1); swap_start = 1'b0;
    step(1);
    check("R11 applied while unarmed", swap_pending, 1'b0);
    swap_enable = 1'b0;
    wr_inactive = 1'b0;
    push(1, 5, "R11"); push(0, 1, "R11"); push(1, 5, "R11"); push(0, 1, "R11");
    start_run();
    drain("R11");

    // R9 held tick stretches the phase
    setup(3, 2);
    push(1, 8, "R9"); push(0, 2, "R9"); push(1, 3, "R9");
    start_run();
    tick = 1'b0;
    step(5);
    tick = 1'b1;
    drain("R9");

    // R8 zero value counts as one
    setup(0, 2);
    push(1, 1, "R8"); push(0, 2, "R8"); push(1, 1, "R8"); push(0, 2, "R8");
    start_run();
    drain("R8");

    report();
    $finish;
  end
endmodule